// File: doc/BRIEF.md
# Single-Bus Adding Datapath with Step Sequencer

This block is a small 16-bit datapath in which every register shares one bus. The storage is a four-word memory, a two-bit address register, a data register with one port facing the memory and one facing the bus, and an ALU. The ALU takes its first operand from a Y register and places its result in a Z register. A hardwired step counter raises the per-step load and drive enables that carry out one fixed transfer: memory word 3 receives the sum of words 1 and 2, and the block then stops and raises a halt flag.

The memory is filled through a preload port while reset is held. Once reset is released, the sequencer runs by itself. A combinational dump port reads any memory word at any time, so a bench can inspect the result. The address register is loaded from a literal held in the control unit and not from the bus. As a result, only the data register, Y and Z ever drive the bus, and at most one of them drives it in any step. When none drives, the bus reads zero.

Top module: `sbus_adder_seq`

## Requirements
- R1: While reset is high, and after it falls until the sequence ends, halt is 0.
- R2: Halt rises at the seventh rising clock edge after reset is released. It then stays high, and the sequencer makes no further changes to memory.
- R3: At the end of the sequence, memory word 3 holds (word 1 + word 2) mod 65536, with any carry out of bit 15 dropped.
- R4: The sequence leaves memory words 0, 1 and 2 unchanged.
- R5: A preload write (pre_we high, pre_data written into word pre_addr) takes effect only at a rising edge while reset is high. When reset is low, the preload port is ignored.
- R6: dump_data always shows memory word dump_addr combinationally, both during reset and during the run.
- R7: At most one register drives the shared bus in any cycle.
- R8: Memory word 3 keeps its preloaded value through the fifth rising edge after reset is released. The sum is written at the sixth edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also enables preload |
| pre_we | input | 1 | Preload write strobe, honoured only during reset |
| pre_addr | input | 2 | Preload word address |
| pre_data | input | 16 | Preload write data |
| dump_addr | input | 2 | Memory word selected for dump |
| dump_data | output | 16 | Contents of the selected memory word |
| halt | output | 1 | High once the sequence has finished |

## Verification
The bench preloads operand pairs chosen to exercise the adder's edges: pairs whose sum carries out of bit 15, pairs that cross the sign bit, all-ones operands and all-zero operands. A design that kept the carry, or that took the wrong word as an operand, would leave the wrong value in word 3. The bench reads word 3 at both the fifth and the sixth edge after reset. A write strobe decoded one step early or one step late therefore shows up as an early or missing sum. The bench also checks that halt rises at the seventh edge and not before, and that preload writes made after halt change nothing. A sequencer that kept running, or a preload port left open outside reset, would corrupt words 0 to 3.

// File: rtl/sbus_adder_seq.sv
module sbus_adder_seq #(
  parameter int WIDTH = 16,
  parameter int WORDS = 4,
  parameter int STEPW = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pre_we,
  input  logic [$clog2(WORDS)-1:0] pre_addr,
  input  logic [WIDTH-1:0]         pre_data,
  input  logic [$clog2(WORDS)-1:0] dump_addr,
  output logic [WIDTH-1:0]         dump_data,
  output logic                     halt
);
  localparam int AW = $clog2(WORDS);
  localparam logic [STEPW-1:0] LAST_STEP = STEPW'(6);

  localparam logic [2:0] OP_ADD  = 3'd0;
  localparam logic [2:0] OP_SUB  = 3'd1;
  localparam logic [2:0] OP_AND  = 3'd2;
  localparam logic [2:0] OP_OR   = 3'd3;
  localparam logic [2:0] OP_XOR  = 3'd4;
  localparam logic [2:0] OP_NOTB = 3'd5;
  localparam logic [2:0] OP_PASS = 3'd6;
  localparam logic [2:0] OP_INCB = 3'd7;

  logic [WIDTH-1:0] mem [WORDS];
  logic [AW-1:0]    mar;
  logic [WIDTH-1:0] mdr, yreg, zreg;
  logic [STEPW-1:0] step;

  logic             mar_ld;
  logic [AW-1:0]    mar_lit;
  logic             rd, wr;
  logic             mdr_in1, mdr_in2, mdr_out2;
  logic             y_in, y_out, z_in, z_out;
  logic [2:0]       alu_op;

  logic [WIDTH-1:0] bus, mem_q, alu_r;

  always_comb begin
    mar_ld = 1'b0; mar_lit = '0; rd = 1'b0; wr = 1'b0;
    mdr_in1 = 1'b0; mdr_in2 = 1'b0; mdr_out2 = 1'b0;
    y_in = 1'b0; y_out = 1'b0; z_in = 1'b0; z_out = 1'b0;
    alu_op = OP_ADD;
    if (!rst && !halt) begin
      case (step)
        3'd0: begin mar_ld = 1'b1; mar_lit = AW'(1); end
        3'd1: begin rd = 1'b1; mdr_in1 = 1'b1; mar_ld = 1'b1; mar_lit = AW'(2); end
        3'd2: begin mdr_out2 = 1'b1; y_in = 1'b1; rd = 1'b1; mdr_in1 = 1'b1; end
        3'd3: begin mdr_out2 = 1'b1; alu_op = OP_ADD; z_in = 1'b1; end
        3'd4: begin z_out = 1'b1; mdr_in2 = 1'b1; mar_ld = 1'b1; mar_lit = AW'(3); end
        3'd5: begin wr = 1'b1; end
        default: ;
      endcase
    end
  end

  assign bus = ({WIDTH{mdr_out2}} & mdr)
             | ({WIDTH{y_out}}    & yreg)
             | ({WIDTH{z_out}}    & zreg);

  assign mem_q     = rd ? mem[mar] : '0;
  assign dump_data = mem[dump_addr];

  always_comb begin
    case (alu_op)
      OP_ADD:  alu_r = yreg + bus;
      OP_SUB:  alu_r = yreg - bus;
      OP_AND:  alu_r = yreg & bus;
      OP_OR:   alu_r = yreg | bus;
      OP_XOR:  alu_r = yreg ^ bus;
      OP_NOTB: alu_r = ~bus;
      OP_PASS: alu_r = yreg;
      default: alu_r = bus + WIDTH'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst && pre_we)
      mem[pre_addr] <= pre_data;
    else if (wr)
      mem[mar] <= mdr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= '0;
      halt <= 1'b0;
      mar  <= '0;
      mdr  <= '0;
      yreg <= '0;
      zreg <= '0;
    end else begin
      if (mar_ld)  mar  <= mar_lit;
      if (mdr_in1) mdr  <= mem_q;
      else if (mdr_in2) mdr <= bus;
      if (y_in)    yreg <= bus;
      if (z_in)    zreg <= alu_r;
      if (step == LAST_STEP) halt <= 1'b1;
      else                   step <= step + STEPW'(1);
    end
  end

  assert_one_driver_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mdr_out2, y_out, z_out}));

  assert_halt_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);

  assert_halt_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    halt |=> $stable(mem[3]) && $stable(mem[0]));

  assert_sum_written_R3: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd5 && !halt) |=> mem[3] == mem[1] + mem[2]);

  assert_no_early_write_R8: assert property (@(posedge clk) disable iff (rst)
    (step < 3'd5) |=> $stable(mem[3]));

  assert_operands_kept_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mem[1]) && $stable(mem[2]));
endmodule

// File: tb/sbus_adder_seq_bench.sv
module sbus_adder_seq_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pre_we = 1'b0;
  logic [1:0]  pre_addr = '0;
  logic [15:0] pre_data = '0;
  logic [1:0]  dump_addr = 2'd3;
  logic [15:0] dump_data;
  logic        halt;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] expq[$];

  sbus_adder_seq u_sbus_adder_seq (
    .clk(clk), .rst(rst), .pre_we(pre_we), .pre_addr(pre_addr),
    .pre_data(pre_data), .dump_addr(dump_addr), .dump_data(dump_data),
    .halt(halt)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    dump_addr = a;
    #1;
    d = dump_data;
  endtask

  initial begin : monitor
    forever begin
      @(posedge halt);
      #2;
      if (expq.size() == 0)
        check(1'b0, "R3 scoreboard empty", dump_data, 16'h0);
      else begin
        logic [15:0] e;
        e = expq.pop_front();
        check(dump_data === e, "R3 sum at halt", dump_data, e);
      end
    end
  end

  task automatic run_case(input logic [15:0] w0, input logic [15:0] a,
                          input logic [15:0] b, input logic [15:0] w3);
    logic [15:0] d;
    @(negedge clk);
    rst = 1'b1;
    pre_we = 1'b1;
    pre_addr = 2'd0; pre_data = w0; @(negedge clk);
    pre_addr = 2'd1; pre_data = a;  @(negedge clk);
    pre_addr = 2'd2; pre_data = b;  @(negedge clk);
    pre_addr = 2'd3; pre_data = w3; @(negedge clk);
    pre_we = 1'b0;
    check(halt === 1'b0, "R1 halt low in reset", {15'b0, halt}, 16'h0);
    peek(2'd1, d);
    check(d === a, "R6 dump during reset", d, a);
    peek(2'd3, d);
    expq.push_back(a + b);
    rst = 1'b0;
    edges(5);
    check(dump_data === w3, "R8 word3 intact after edge 5", dump_data, w3);
    check(halt === 1'b0, "R1 halt low mid-run", {15'b0, halt}, 16'h0);
    edges(1);
    check(dump_data === a + b, "R8 sum after edge 6", dump_data, a + b);
    check(halt === 1'b0, "R2 halt not before edge 7", {15'b0, halt}, 16'h0);
    edges(1);
    check(halt === 1'b1, "R2 halt at edge 7", {15'b0, halt}, 16'h1);
    edges(1);
    pre_we = 1'b1; pre_addr = 2'd0; pre_data = ~w0;
    edges(1);
    pre_addr = 2'd3; pre_data = ~(a + b);
    edges(1);
    pre_we = 1'b0;
    edges(3);
    check(halt === 1'b1, "R2 halt stays high", {15'b0, halt}, 16'h1);
    peek(2'd0, d);
    check(d === w0, "R5 preload ignored outside reset / R4 word0", d, w0);
    peek(2'd1, d);
    check(d === a, "R4 word1 kept", d, a);
    peek(2'd2, d);
    check(d === b, "R4 word2 kept", d, b);
    peek(2'd3, d);
    check(d === a + b, "R5 R7 word3 final", d, a + b);
  endtask

  initial begin : driver
    edges(2);
    check(halt === 1'b0, "R1 reset state", {15'b0, halt}, 16'h0);
    run_case(16'h1111, 16'h0012, 16'h0034, 16'hDEAD);
    run_case(16'hA5A5, 16'hFFFF, 16'h0001, 16'h1234);
    run_case(16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000);
    run_case(16'h5A5A, 16'h8000, 16'h8000, 16'h7777);
    run_case(16'hC3C3, 16'h7FFF, 16'h0001, 16'hFFFF);
    run_case(16'hFFFF, 16'h0000, 16'h0000, 16'hBEEF);
    edges(2);
    check(expq.size() == 0, "R2 every run halted", 16'(expq.size()), 16'h0);
    finish_run();
  end

  initial begin : watchdog
    #(PERIOD * 5000);
    check(1'b0, "R2 watchdog expired", 16'h0, 16'h1);
    finish_run();
  end
endmodule